// File: doc/BRIEF.md
# Dual-Coil Meter PWM Driver

This block drives one needle-type stepper gauge. It takes two 8-bit duty values, one for the sine coil and one for the cosine coil. An 8-bit up-counter advances on every cycle where the clock-enable tick is high. Each coil has a compare channel whose output goes high when the counter wraps and low when the counter reaches that channel's active compare value. The active compare values are shadow copies of the software-written duty registers. They are refreshed only at a counter wrap, and only after software has raised an update-request flag. Hardware clears that flag as soon as the copy has been made.

Four output pins carry the coil signals in the order sine+, sine−, cosine+, cosine−. In full-bridge mode, each coil's pulse goes to its positive or its negative pin, as a per-coil direction bit chooses, and the other pin of that coil stays low. In half-bridge mode, each coil's pulse drives both of its pins and the direction bits have no effect.

A simple write port sets the registers. Address 0 is the sine duty and address 1 is the cosine duty. Address 2 is the control byte: bit 0 is the sine direction, bit 1 is the cosine direction, bit 2 is the half-bridge mode and bit 3 is the update request. Writing a 1 to bit 3 sets the request; writing a 0 there leaves the request unchanged. The request state is visible on `upd_pending`. Software writes the duty registers only while `upd_pending` is 0.

Top module: `meter_pwm_drv`

## Requirements
- R1: The counter advances by one only on cycles with `tick_en` high and wraps from 255 to 0. While `tick_en` stays low, all four pins hold their values.
- R2: After each wrap a coil's pulse is high for exactly as many ticks as its active compare value, so the high time is N of every 256 ticks. A compare value of 0 keeps the pulse constantly low.
- R3: Duty values written at address 0 or 1 take effect only at a counter wrap that occurs while the update request is set. Without a request, the written values leave the pin waveforms unchanged.
- R4: Writing control bit 3 = 1 sets `upd_pending`. Hardware clears it at the next counter wrap, which is the moment of the shadow transfer. It stays at 1 until that wrap.
- R5: In full-bridge mode (control bit 2 = 0), direction bit 0 steers the sine pulse and direction bit 1 steers the cosine pulse. A direction value of 0 selects the positive pin and 1 selects the negative pin. The unselected pin of each coil is held low.
- R6: In half-bridge mode (control bit 2 = 1), the sine pulse drives both sine pins and the cosine pulse drives both cosine pins, whatever the direction bits are.
- R7: The pin order is fixed: `pwm_pins[0]` is sine+, `[1]` is sine−, `[2]` is cosine+ and `[3]` is cosine−.
- R8: Reset clears the counter, the duty and shadow registers, the control bits and the update request, so all pins start low and `upd_pending` starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance enable (prescaler tick) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 sine duty, 1 cosine duty, 2 control |
| cfg_wdata | input | 8 | Write data |
| pwm_pins | output | 4 | Coil outputs: sine+, sine−, cosine+, cosine− |
| upd_pending | output | 1 | Update request still waiting for a counter wrap |

## Verification
A wrong counter or channel state shows up as a wrong high-time count on a pin within one 256-tick period. The bench counts high samples over whole periods, so an off-by-one width or a missed zero case appears as a count error. A shadow copy made at the wrong moment, or made without a request, changes those counts in the period that follows. A flag that never clears stalls `upd_pending` past one period. A steering error is visible at once, because a pulse lands on the wrong pin or on both pins of a coil.

// File: rtl/meter_pwm_pkg.sv
package meter_pwm_pkg;

  localparam int DUTY_W = 8;

  typedef enum logic [1:0] {
    ADDR_SIN  = 2'd0,
    ADDR_COS  = 2'd1,
    ADDR_CTRL = 2'd2
  } cfg_addr_e;

  // Next pulse level: set at wrap unless compare is zero, cleared on match.
  function automatic logic pulse_next(input logic [DUTY_W-1:0] cnt_nxt,
                                      input logic [DUTY_W-1:0] cmp_old,
                                      input logic [DUTY_W-1:0] cmp_new,
                                      input logic              wrap,
                                      input logic              cur);
    if (wrap)                 return (cmp_new != '0);
    else if (cnt_nxt == cmp_old) return 1'b0;
    else                      return cur;
  endfunction

  // Pin steering: order sine+, sine-, cosine+, cosine-.
  function automatic logic [3:0] steer_pins(input logic       sin_p,
                                            input logic       cos_p,
                                            input logic [1:0] dir,
                                            input logic       half);
    logic [3:0] p;
    if (half) p = {cos_p, cos_p, sin_p, sin_p};
    else      p = {cos_p & dir[1], cos_p & ~dir[1], sin_p & dir[0], sin_p & ~dir[0]};
    return p;
  endfunction

endpackage

// File: rtl/mpd_tick_counter.sv
module mpd_tick_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign wrap_evt = tick_en && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (tick_en) cnt <= cnt + 1'b1;
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt == '0));

endmodule

// File: rtl/mpd_cmp_chan.sv
module mpd_cmp_chan
  import meter_pwm_pkg::*;
#(
  parameter int CNT_W = DUTY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wrap_evt,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_reg,
  output logic             pulse
);
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] shadow_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  assign shadow_nxt = load ? duty_reg : shadow_q;
  assign cnt_nxt    = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pulse    <= 1'b0;
    end else begin
      shadow_q <= shadow_nxt;
      if (tick_en) pulse <= pulse_next(cnt_nxt, shadow_q, shadow_nxt, wrap_evt, pulse);
    end
  end

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shadow_q));

  // R2
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_q == '0) |-> !pulse);

  // R2
  rise_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> (cnt == '0));

endmodule

// File: rtl/mpd_steer.sv
module mpd_steer
  import meter_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sin_p,
  input  logic       cos_p,
  input  logic [1:0] dir,
  input  logic       half,
  output logic [3:0] pins
);
  assign pins = steer_pins(sin_p, cos_p, dir, half);

  // R5
  unsel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half |-> (!(pins[0] && pins[1]) && !(pins[2] && pins[3])));

  // R6
  half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> ((pins[0] == pins[1]) && (pins[2] == pins[3])));

endmodule

// File: rtl/meter_pwm_drv.sv
module meter_pwm_drv
  import meter_pwm_pkg::*;
#(
  parameter int DW = DUTY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [3:0]    pwm_pins,
  output logic          upd_pending
);
  localparam int NCOIL = 2;

  logic [DW-1:0] duty_q [NCOIL];
  logic [1:0]    dir_q;
  logic          half_q;
  logic [DW-1:0] cnt;
  logic          wrap_evt;
  logic          req_set;
  logic          xfer_evt;
  logic [NCOIL-1:0] coil_pulse;

  assign req_set  = cfg_we && (cfg_addr == ADDR_CTRL) && cfg_wdata[3];
  assign xfer_evt = wrap_evt && upd_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q[0]   <= '0;
      duty_q[1]   <= '0;
      dir_q       <= '0;
      half_q      <= 1'b0;
      upd_pending <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          ADDR_SIN:  duty_q[0] <= cfg_wdata;
          ADDR_COS:  duty_q[1] <= cfg_wdata;
          ADDR_CTRL: begin
            dir_q  <= cfg_wdata[1:0];
            half_q <= cfg_wdata[2];
          end
          default: ;
        endcase
      end
      if (req_set)       upd_pending <= 1'b1;
      else if (xfer_evt) upd_pending <= 1'b0;
    end
  end

  mpd_tick_counter #(.CNT_W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt(cnt), .wrap_evt(wrap_evt)
  );

  for (genvar g = 0; g < NCOIL; g++) begin : g_coil
    mpd_cmp_chan #(.CNT_W(DW)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wrap_evt(wrap_evt),
      .load(xfer_evt), .cnt(cnt), .duty_reg(duty_q[g]), .pulse(coil_pulse[g])
    );
  end

  mpd_steer u_steer (
    .clk(clk), .rst_n(rst_n), .sin_p(coil_pulse[0]), .cos_p(coil_pulse[1]),
    .dir(dir_q), .half(half_q), .pins(pwm_pins)
  );

  // R4
  upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_evt && !req_set) |=> !upd_pending);

  // R4
  upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pending && !wrap_evt) |=> upd_pending);

endmodule

// File: tb/meter_pwm_drv_tb_top.sv
module meter_pwm_drv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] pwm_pins;
  logic       upd_pending;

  int checks = 0;
  int errors = 0;
  int tick_mode = 0; // 0 off, 1 every cycle, 2 every other cycle
  bit done = 0;

  always #2 clk = ~clk;

  meter_pwm_drv dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pwm_pins(pwm_pins),
    .upd_pending(upd_pending)
  );

  always @(negedge clk) begin
    if (tick_mode == 1)      tick_en <= 1'b1;
    else if (tick_mode == 2) tick_en <= ~tick_en;
    else                     tick_en <= 1'b0;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Wait (at negedges) until the update request has been consumed.
  task automatic wait_update(output int waited);
    waited = 0;
    while (upd_pending && waited < 2000) begin
      @(negedge clk); waited++;
    end
  endtask

  // Count high samples per pin over n negedges.
  task automatic measure(input int n, output int c0, output int c1, output int c2, output int c3);
    c0 = 0; c1 = 0; c2 = 0; c3 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c0 += int'(pwm_pins[0]); c1 += int'(pwm_pins[1]);
      c2 += int'(pwm_pins[2]); c3 += int'(pwm_pins[3]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8", "pins after reset", pwm_pins, 0);
    chk("R8", "upd_pending after reset", upd_pending, 0);
  endtask

  task automatic t_full_pos();
    int w, a, b, c, d;
    wr(0, 8'd64); wr(1, 8'd192); wr(2, 8'b1000);
    chk("R4", "flag set after request", upd_pending, 1);
    wait_update(w);
    chk("R4", "flag cleared within one period", int'(w < 260), 1);
    measure(256, a, b, c, d);
    chk("R2", "sine+ high ticks", a, 64);
    chk("R5", "sine- held low", b, 0);
    chk("R2", "cosine+ high ticks", c, 192);
    chk("R5", "cosine- held low", d, 0);
  endtask

  task automatic t_full_neg();
    int a, b, c, d;
    wr(2, 8'b0011);
    measure(256, a, b, c, d);
    chk("R5", "sine+ low when dir0=1", a, 0);
    chk("R7", "sine- pin carries sine", b, 64);
    chk("R5", "cosine+ low when dir1=1", c, 0);
    chk("R7", "cosine- pin carries cosine", d, 192);
    wr(2, 8'b0010);
    measure(256, a, b, c, d);
    chk("R5", "mixed dir sine+", a, 64);
    chk("R5", "mixed dir cosine-", d, 192);
    chk("R5", "mixed dir unselected", b + c, 0);
  endtask

  task automatic t_half();
    int a, b, c, d;
    wr(2, 8'b0111);
    measure(256, a, b, c, d);
    chk("R6", "half sine+", a, 64);
    chk("R6", "half sine-", b, 64);
    chk("R6", "half cosine+", c, 192);
    chk("R6", "half cosine-", d, 192);
  endtask

  task automatic t_no_request();
    int a, b, c, d;
    wr(2, 8'b0000);
    wr(0, 8'd10); wr(1, 8'd20);
    chk("R4", "flag stays low without request", upd_pending, 0);
    measure(256, a, b, c, d);
    chk("R3", "sine unchanged without request", a, 64);
    chk("R3", "cosine unchanged without request", c, 192);
  endtask

  task automatic t_extremes();
    int w, a, b, c, d;
    wr(0, 8'd0); wr(1, 8'd255); wr(2, 8'b1000);
    measure(100, a, b, c, d);
    chk("R4", "flag held until wrap", upd_pending, 1);
    wait_update(w);
    measure(256, a, b, c, d);
    chk("R2", "compare 0 constant low", a, 0);
    chk("R2", "compare 255 high ticks", c, 255);
    wr(0, 8'd1); wr(1, 8'd128); wr(2, 8'b1000);
    wait_update(w);
    measure(256, a, b, c, d);
    chk("R2", "compare 1 high ticks", a, 1);
    chk("R3", "new cosine after transfer", c, 128);
  endtask

  task automatic t_tick_gate();
    int w, a, b, c, d;
    logic [3:0] first;
    tick_mode = 0;
    repeat (2) @(negedge clk);
    first = pwm_pins;
    a = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm_pins != first) a++;
    end
    chk("R1", "pins frozen without tick", a, 0);
    tick_mode = 2;
    wr(0, 8'd50); wr(1, 8'd3); wr(2, 8'b1000);
    wait_update(w);
    measure(512, a, b, c, d);
    chk("R1", "half-rate tick sine width", a, 100);
    chk("R1", "half-rate tick cosine width", c, 6);
    tick_mode = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    tick_mode = 1;
    t_full_pos();
    t_full_neg();
    t_half();
    t_no_request();
    t_extremes();
    t_tick_gate();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule